// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a system against software that stops responding. It runs from a free-running oscillator clock. An 8-bit prescaler divides that clock by a power of two chosen by software, from 2 up to 256. Each prescaled tick advances a main counter, which is 15 bits wide by default. When the main counter wraps past its all-ones value, the block raises a one-cycle reset request toward the system and latches a sticky cause flag. Software can read that flag after the reset to learn why the reset occurred.

Software reaches the block through one 8-bit control register on a simple write-strobe bus; read data is always presented. Once the watchdog is armed, software cannot disarm it; only the power-on reset can. To keep the system alive, software must restart the count before it wraps. Two status inputs from the clock controller pause counting:
- The power-down input always pauses the count.
- The idle input pauses the count unless software has asked for counting to continue during idle.

Top module: `wdog_prescaled`

## Requirements
- R1: After power-on reset, `reg_rdata` reads 0x00 and `wdt_rst_o` is low.
- R2: The cause flag (bit 7) becomes 1 when the counter wraps and then stays 1. Writing 0 to bit 7 clears it. Writing 1 to bit 7 leaves it unchanged.
- R3: The arm bit (bit 5) is set by writing 1. Writing 0 to bit 5 never clears it; only the power-on reset does.
- R4: Writing 1 to the restart bit (bit 4) makes bit 4 read 1 for exactly one cycle, then 0. That cycle zeroes the prescaler and the counter and does not count, so the next timeout arrives 2^CNT_W × 2^(sel+1) + 1 cycles after the write edge.
- R5: The divide-select field (bits 2:0, value sel) gives a divide ratio of 2^(sel+1). Once armed at a write edge with the count at zero, `wdt_rst_o` first rises after exactly 2^CNT_W × 2^(sel+1) further clock edges.
- R6: While `idle_i` is high and the idle-run bit (bit 3) is 0, counting pauses. When bit 3 is 1, idle has no effect on the count.
- R7: While `pdown_i` is high, counting pauses whatever bit 3 holds.
- R8: `wdt_rst_o` is high for exactly one cycle. That cycle clears the counter and prescaler but leaves the flag and the arm bit set, so successive pulses are 2^CNT_W × 2^(sel+1) + 1 cycles apart.
- R9: Bit 6 always reads 0, and writes to it are ignored.
- R10: While the arm bit is 0, the counter never moves and no reset request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| idle_i | input | 1 | CPU is in idle mode |
| pdown_i | input | 1 | CPU is in power-down mode |
| wdt_rst_o | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
The assertions check every cycle that:
- the flag and the arm bit only drop through their permitted paths;
- the restart bit lasts one cycle and zeroes the count;
- power-down freezes the count;
- the reset pulse lasts one cycle and coincides with a set flag;
- the counter stays at zero while disarmed.

Only the bench scenarios can show the exact timeout length for each divide select, the one-cycle stretch a restart adds, the pause length that idle and power-down add, and the spacing between repeated pulses. These are whole-timeout quantities that a single-cycle property does not capture.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       idle_i,
  input  logic       pdown_i,
  output logic       wdt_rst_o
);
  localparam int PRE_W = 8;
  localparam int SEL_W = $clog2(PRE_W);

  logic             flag_q, arm_q, restart_q, idle_run_q, rst_q;
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_q, tap_mask;
  logic [CNT_W-1:0] cnt_q;
  logic             run, tick, wrap;

  always_comb begin
    tap_mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i <= int'(sel_q)) tap_mask[i] = 1'b1;
  end

  assign run  = arm_q && !pdown_i && (!idle_i || idle_run_q) && !restart_q && !rst_q;
  assign tick = run && ((pre_q & tap_mask) == tap_mask);
  assign wrap = tick && (&cnt_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q     <= 1'b0;
      arm_q      <= 1'b0;
      restart_q  <= 1'b0;
      idle_run_q <= 1'b0;
      sel_q      <= '0;
    end else begin
      if (wrap)                       flag_q <= 1'b1;
      else if (reg_we && !reg_wdata[7]) flag_q <= 1'b0;
      if (reg_we) begin
        arm_q      <= arm_q | reg_wdata[5];
        idle_run_q <= reg_wdata[3];
        sel_q      <= reg_wdata[SEL_W-1:0];
      end
      restart_q <= reg_we && reg_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= wrap;
      if (restart_q || rst_q) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (run) begin
        pre_q <= pre_q + 1'b1;
        if (tick) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign reg_rdata = {flag_q, 1'b0, arm_q, restart_q, idle_run_q, sel_q};
  assign wdt_rst_o = rst_q;

  // R2
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    flag_q && !(reg_we && !reg_wdata[7]) |=> flag_q);
  // R3
  a_r3_arm_set_only: assert property (@(posedge clk) disable iff (!por_n)
    arm_q |=> arm_q);
  // R4
  a_r4_restart_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    restart_q && !reg_we |=> !restart_q);
  a_r4_restart_zeroes: assert property (@(posedge clk) disable iff (!por_n)
    restart_q |=> (cnt_q == '0) && (pre_q == '0));
  // R7
  a_r7_pdown_freeze: assert property (@(posedge clk) disable iff (!por_n)
    pdown_i && !restart_q && !rst_q |=> $stable(cnt_q) && $stable(pre_q));
  // R8
  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_o |=> !wdt_rst_o);
  a_r8_pulse_flagged: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_o |-> flag_q && arm_q);
  // R10
  a_r10_idle_when_disarmed: assert property (@(posedge clk) disable iff (!por_n)
    !arm_q |-> (cnt_q == '0) && !wdt_rst_o);
endmodule

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;
  localparam int CW = 4;
  localparam int BASE = 1 << CW;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       idle_i = 1'b0;
  logic       pdown_i = 1'b0;
  logic       wdt_rst_o;
  int checks = 0;
  int errors = 0;

  wdog_prescaled #(.CNT_W(CW)) u_wdog_prescaled (
    .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .idle_i(idle_i), .pdown_i(pdown_i), .wdt_rst_o(wdt_rst_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0; reg_we = 1'b0; idle_i = 1'b0; pdown_i = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // mode: 0 none, 1 idle window, 2 power-down window; window edges 10..59
  task automatic edges_to_pulse(input int mode, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      idle_i  = (mode == 1) && (n >= 10) && (n < 60);
      pdown_i = (mode == 2) && (n >= 10) && (n < 60);
      @(posedge clk);
      n++;
      @(negedge clk);
      if (wdt_rst_o) break;
    end
    idle_i = 1'b0; pdown_i = 1'b0;
  endtask

  task automatic t_reset();
    do_por();
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 rst", int'(wdt_rst_o), 0);
  endtask

  task automatic t_disarmed();
    int n;
    do_por();
    wr(8'h0B);
    edges_to_pulse(0, 5000, n);
    check("R10 no pulse while disarmed", int'(wdt_rst_o), 0);
    check("R10 flag", int'(reg_rdata[7]), 0);
  endtask

  task automatic t_timeout(input int sel);
    int n;
    do_por();
    wr(8'h20 | 8'(sel));
    check("R5 rdata after arm", int'(reg_rdata), 32 + sel);
    edges_to_pulse(0, 10000, n);
    check("R5 timeout cycles", n, BASE << (sel + 1));
    check("R2 flag set", int'(reg_rdata[7]), 1);
  endtask

  task automatic t_flag_arm_bit6();
    int n;
    do_por();
    wr(8'h20);
    edges_to_pulse(0, 1000, n);
    @(negedge clk);
    check("R8 pulse width", int'(wdt_rst_o), 0);
    check("R8 flag kept", int'(reg_rdata[7]), 1);
    check("R8 arm kept", int'(reg_rdata[5]), 1);
    wr(8'h80);
    check("R2 write 1 keeps flag", int'(reg_rdata[7]), 1);
    wr(8'h40);
    check("R2 write 0 clears flag", int'(reg_rdata[7]), 0);
    check("R3 arm not cleared", int'(reg_rdata[5]), 1);
    check("R9 bit6 reads 0", int'(reg_rdata[6]), 0);
    wr(8'h80);
    check("R2 write 1 does not set", int'(reg_rdata[7]), 0);
  endtask

  task automatic t_period();
    int n;
    do_por();
    wr(8'h21);
    edges_to_pulse(0, 1000, n);
    check("R5 first", n, BASE * 4);
    edges_to_pulse(0, 1000, n);
    check("R8 period", n, BASE * 4 + 1);
    edges_to_pulse(0, 1000, n);
    check("R8 period again", n, BASE * 4 + 1);
  endtask

  task automatic t_restart();
    int n;
    do_por();
    wr(8'h20);
    repeat (20) @(negedge clk);
    reg_we = 1'b1; reg_wdata = 8'h30;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    check("R4 bit4 high", int'(reg_rdata[4]), 1);
    @(posedge clk);
    @(negedge clk);
    check("R4 bit4 self-clears", int'(reg_rdata[4]), 0);
    edges_to_pulse(0, 1000, n);
    check("R4 timeout after restart", n + 1, BASE * 2 + 1);
  endtask

  task automatic t_idle(input bit keep);
    int n;
    do_por();
    wr(keep ? 8'h28 : 8'h20);
    edges_to_pulse(1, 1000, n);
    if (keep) check("R6 idle-run ignores idle", n, BASE * 2);
    else      check("R6 idle pauses", n, BASE * 2 + 50);
  endtask

  task automatic t_pdown();
    int n;
    do_por();
    wr(8'h28);
    edges_to_pulse(2, 1000, n);
    check("R7 power-down pauses", n, BASE * 2 + 50);
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_disarmed();
    t_timeout(0);
    t_timeout(2);
    t_timeout(7);
    t_flag_arm_bit6();
    t_period();
    t_restart();
    t_idle(1'b0);
    t_idle(1'b1);
    t_pdown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule